// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits on the host side of an asynchronous DRAM and keeps the part alive. After reset it holds every strobe inactive for a long settling pause. It then runs a fixed number of wake-up cycles on its own. Only after that does it declare the memory usable. From that point a free-running interval timer creates refresh obligations at a steady rate. Each obligation is offered to an access arbiter through a request/grant handshake.

Every refresh is a CAS-before-RAS cycle. Both byte column strobes fall together, the row strobe follows, the column strobes release, and the row strobe then precharges. No row address is ever supplied, because the memory steps its own internal row counter. All timing values are given in clock cycles.

Obligations that the arbiter has not yet granted are counted. If the count reaches its limit, the retention window may already have been violated. In that case the block sets a sticky error flag, withdraws its ready flag and runs the whole wake-up sequence again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low, ras_n_o, lcas_n_o and ucas_n_o are high, and ready_o, ref_req_o and ovf_err_o are low.
- R2: No strobe goes low during the first PAUSE_CYC clock cycles after reset release. The first column strobe fall comes no later than two cycles after the pause ends.
- R3: After the pause, exactly WAKE_CNT refresh cycles run without any grant, and ready_o then rises with ref_req_o low.
- R4: In every refresh cycle, lcas_n_o and ucas_n_o fall together while ras_n_o is high. They lead the fall of ras_n_o by T_CSR cycles and stay low for T_CHR cycles after it. ras_n_o then stays low for exactly T_RAS cycles.
- R5: Between two falls of ras_n_o, ras_n_o is high for at least T_RP cycles.
- R6: The first refresh request becomes visible REF_INTERVAL cycles after ready_o rises. A further obligation is added every REF_INTERVAL cycles while ready_o is high.
- R7: A request that is not granted stays asserted, and no strobe moves while it waits.
- R8: A grant is taken in a cycle where ref_req_o and ref_gnt_i are both high. Each grant starts one refresh cycle and removes one pending obligation. ref_req_o falls once none remain.
- R9: ref_req_o is low whenever a refresh cycle is in progress, so it is high only while all strobes are high.
- R10: The error condition occurs when an obligation arrives and no grant is taken in that cycle, while MAX_BACKLOG-1 obligations are already pending. ovf_err_o then rises and stays high until reset. ready_o falls in the same cycle, and exactly WAKE_CNT cycles run before ready_o rises again.
- R11: lcas_n_o always equals ucas_n_o.
- R12: ref_gnt_i has no effect while ref_req_o is low: no refresh cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_req_o | output | 1 | Refresh obligation pending and engine idle |
| ref_gnt_i | input | 1 | Arbiter hands the DRAM pins to the block |
| ready_o | output | 1 | Initialization complete, accesses allowed |
| ovf_err_o | output | 1 | Sticky: pending obligations hit the limit |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower byte column strobe, active low |
| ucas_n_o | output | 1 | Upper byte column strobe, active low |

## Verification
The bench drives the sequencer through five distinct grant patterns.

- **No grants during power-up.** This shows the pause length and the self-started wake-up count.
- **First request after ready.** The bench times the first request against ready_o, which pins down the interval timer.
- **Several obligations, then one grant at a time.** Three obligations build up before any grant is given. This separates real counting of the pending obligations from a single-bit pending flag, and it shows that ungranted requests hold steady.
- **Stray grant while idle.** A grant with no request pending must start no cycle.
- **Starvation until the limit.** Withholding grants until the limit exercises the sticky error and the rerun of the wake-up sequence.

Throughout all of this, a pin monitor measures every column lead, column hold, row low width and precharge gap.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {PH_PAUSE, PH_WAKE, PH_RUN} phase_e;
  typedef enum logic [1:0] {CY_IDLE, CY_CAS_LEAD, CY_RAS_LOW, CY_PRECHG} cyc_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned INTERVAL = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int unsigned MAX_BACKLOG = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic dec_i,
  output logic pending_o,
  output logic ovf_o
);
  localparam int unsigned BW = $clog2(MAX_BACKLOG + 1);
  localparam logic [BW-1:0] EDGE = BW'(MAX_BACKLOG - 1);

  logic [BW-1:0] cnt_q;

  assign pending_o = (cnt_q != '0);
  assign ovf_o     = inc_i && !dec_i && (cnt_q == EDGE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || ovf_o)    cnt_q <= '0;
    else if (inc_i && !dec_i)   cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/cbr_cycle_gen.sv
module cbr_cycle_gen
  import dram_ref_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_CHR = 1,
  parameter int unsigned T_RAS = 4,
  parameter int unsigned T_RP  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned M1    = (T_CSR > T_CHR) ? T_CSR : T_CHR;
  localparam int unsigned M2    = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int unsigned T_MAX = (M1 > M2) ? M1 : M2;
  localparam int unsigned CW    = $clog2(T_MAX + 1);
  localparam logic [CW-1:0] CSR_END = CW'(T_CSR - 1);
  localparam logic [CW-1:0] RAS_END = CW'(T_RAS - 1);
  localparam logic [CW-1:0] RP_END  = CW'(T_RP - 1);
  localparam logic [CW-1:0] CHR_LIM = CW'(T_CHR);

  cyc_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CY_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        CY_IDLE: begin
          cnt_q <= '0;
          if (start_i) st_q <= CY_CAS_LEAD;
        end
        CY_CAS_LEAD: begin
          if (cnt_q == CSR_END) begin
            st_q  <= CY_RAS_LOW;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        CY_RAS_LOW: begin
          if (cnt_q == RAS_END) begin
            st_q  <= CY_PRECHG;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        CY_PRECHG: begin
          if (cnt_q == RP_END) begin
            st_q  <= CY_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          st_q  <= CY_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign busy_o  = (st_q != CY_IDLE);
  assign done_o  = (st_q == CY_PRECHG) && (cnt_q == RP_END);
  assign ras_n_o = (st_q != CY_RAS_LOW);
  // column strobe leads the row strobe, then holds T_CHR cycles into it
  assign cas_n_o = !((st_q == CY_CAS_LEAD) ||
                     ((st_q == CY_RAS_LOW) && (cnt_q < CHR_LIM)));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 20000,
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned REF_INTERVAL = 1562,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_CHR        = 1,
  parameter int unsigned T_RAS        = 4,
  parameter int unsigned T_RP         = 3,
  parameter int unsigned MAX_BACKLOG  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ref_req_o,
  input  logic ref_gnt_i,
  output logic ready_o,
  output logic ovf_err_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned WW = $clog2(WAKE_CNT + 1);
  localparam logic [PW-1:0] PAUSE_END = PW'(PAUSE_CYC - 1);
  localparam logic [WW-1:0] WAKE_END  = WW'(WAKE_CNT - 1);

  phase_e        phase_q;
  logic [PW-1:0] pause_q;
  logic [WW-1:0] wake_q;
  logic          err_q;

  logic tick, pending, ovf, busy, done, cas_n, grant_ok, start;

  assign grant_ok = ref_req_o && ref_gnt_i;
  assign start    = ((phase_q == PH_WAKE) && !busy) || grant_ok;

  ref_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (phase_q == PH_RUN),
    .tick_o (tick)
  );

  ref_backlog #(.MAX_BACKLOG(MAX_BACKLOG)) u_backlog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (phase_q != PH_RUN),
    .inc_i     (tick),
    .dec_i     (grant_ok),
    .pending_o (pending),
    .ovf_o     (ovf)
  );

  cbr_cycle_gen #(
    .T_CSR (T_CSR),
    .T_CHR (T_CHR),
    .T_RAS (T_RAS),
    .T_RP  (T_RP)
  ) u_cycle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .done_o  (done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PAUSE;
      pause_q <= '0;
      wake_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_PAUSE: begin
          if (pause_q == PAUSE_END) phase_q <= PH_WAKE;
          else                      pause_q <= pause_q + 1'b1;
        end
        PH_WAKE: begin
          if (done) begin
            if (wake_q == WAKE_END) begin
              phase_q <= PH_RUN;
              wake_q  <= '0;
            end else wake_q <= wake_q + 1'b1;
          end
        end
        PH_RUN: begin
          // retention window at risk: flag it and re-wake the part
          if (ovf) begin
            phase_q <= PH_WAKE;
            wake_q  <= '0;
            err_q   <= 1'b1;
          end
        end
        default: phase_q <= PH_PAUSE;
      endcase
    end
  end

  assign ref_req_o = (phase_q == PH_RUN) && pending && !busy;
  assign ready_o   = (phase_q == PH_RUN);
  assign ovf_err_o = err_q;
  assign lcas_n_o  = cas_n;
  assign ucas_n_o  = cas_n;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned T_RAS     = 4,
  parameter int unsigned T_RP      = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_req_o,
  input logic ref_gnt_i,
  input logic ready_o,
  input logic ovf_err_o,
  input logic ras_n_o,
  input logic lcas_n_o,
  input logic ucas_n_o
);
  localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
  localparam int unsigned LW = $clog2(T_RAS + 2);
  localparam int unsigned HW = $clog2(T_RP + 1);

  logic [PW-1:0] boot_q;
  logic [LW-1:0] lo_q;
  logic [HW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= '0;
      lo_q   <= '0;
      hi_q   <= HW'(T_RP);
    end else begin
      if (boot_q != PW'(PAUSE_CYC)) boot_q <= boot_q + 1'b1;
      if (!ras_n_o) begin
        hi_q <= '0;
        if (lo_q != LW'(T_RAS + 1)) lo_q <= lo_q + 1'b1;
      end else begin
        lo_q <= '0;
        if (hi_q != HW'(T_RP)) hi_q <= hi_q + 1'b1;
      end
    end
  end

  AST_PAUSE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_q < PW'(PAUSE_CYC)) |-> (ras_n_o && lcas_n_o && ucas_n_o)); // R2

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!lcas_n_o && !ucas_n_o && $past(!lcas_n_o))); // R4

  AST_RAS_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_q == LW'(T_RAS))); // R4

  AST_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_q >= HW'(T_RP))); // R5

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_gnt_i) |=> (ref_req_o || !ready_o)); // R7

  AST_REQ_IDLE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> (ras_n_o && lcas_n_o && ucas_n_o)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_err_o |=> ovf_err_o); // R10

  AST_ERR_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_err_o) |-> !ready_o); // R10
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .PAUSE_CYC (PAUSE_CYC),
  .T_RAS     (T_RAS),
  .T_RP      (T_RP)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ref_req_o (ref_req_o),
  .ref_gnt_i (ref_gnt_i),
  .ready_o   (ready_o),
  .ovf_err_o (ovf_err_o),
  .ras_n_o   (ras_n_o),
  .lcas_n_o  (lcas_n_o),
  .ucas_n_o  (ucas_n_o)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PAUSE      = 30;
  localparam int WAKE       = 8;
  localparam int INTERVAL   = 80;
  localparam int TCSR       = 1;
  localparam int TCHR       = 2;
  localparam int TRAS       = 4;
  localparam int TRP        = 3;
  localparam int MAXB       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, ready, err, ras_n, lcas_n, ucas_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .REF_INTERVAL(INTERVAL),
    .T_CSR(TCSR), .T_CHR(TCHR), .T_RAS(TRAS), .T_RP(TRP), .MAX_BACKLOG(MAXB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_req_o(req), .ref_gnt_i(gnt),
    .ready_o(ready), .ovf_err_o(err), .ras_n_o(ras_n),
    .lcas_n_o(lcas_n), .ucas_n_o(ucas_n)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pin monitor, sampled on the falling edge
  int cyc = 0, first_cas = -1, ras_falls = 0;
  int lead = 0, hold = 0, lo_run = 0, hi_run = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (lcas_n != ucas_n) chk(1'b0, "R11 byte strobes differ", lcas_n, ucas_n);
      if (req && !(ras_n && lcas_n)) chk(1'b0, "R9 request during cycle", ras_n, 1);
      if (prev_cas && !lcas_n) begin
        if (first_cas < 0) first_cas = cyc;
        chk(ras_n == 1'b1, "R4 column falls with row high", ras_n, 1);
      end
      if (prev_ras && !ras_n) begin
        chk(lead == TCSR, "R4 column lead", lead, TCSR);
        chk(hi_run >= TRP, "R5 precharge", hi_run, TRP);
        ras_falls++;
      end
      if (!prev_cas && lcas_n && !ras_n) chk(hold == TCHR, "R4 column hold", hold, TCHR);
      if (!prev_ras && ras_n) chk(lo_run == TRAS, "R4 row low width", lo_run, TRAS);
      if (!lcas_n && ras_n) lead++; else if (lcas_n) lead = 0;
      if (!lcas_n && !ras_n) hold++; else hold = 0;
      if (!ras_n) begin lo_run++; hi_run = 0; end
      else begin hi_run++; lo_run = 0; end
      prev_ras = ras_n;
      prev_cas = lcas_n;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    chk(ras_n && lcas_n && ucas_n, "R1 strobes idle in reset", {ras_n, lcas_n, ucas_n}, 7);
    chk(!ready && !req && !err, "R1 flags low in reset", {ready, req, err}, 0);
  endtask

  task automatic t_power_up();
    int n = 0;
    while (!ready && n < 2000) begin step(1); n++; end
    chk(first_cas >= PAUSE && first_cas <= PAUSE + 2, "R2 pause length", first_cas, PAUSE + 1);
    chk(ras_falls == WAKE, "R3 wake cycle count", ras_falls, WAKE);
    chk(ready && !req && !err, "R3 ready without request", {ready, req, err}, 4);
  endtask

  task automatic t_first_req();
    int n = 0;
    do begin step(1); n++; end while (!req && n < 4 * INTERVAL);
    chk(n == INTERVAL, "R6 first request delay", n, INTERVAL);
  endtask

  task automatic t_backlog_grants();
    int f0 = ras_falls;
    int g = 0;
    step(2 * INTERVAL + 2);
    chk(req == 1'b1, "R7 request held without grant", req, 1);
    chk(ras_falls == f0, "R7 no cycle without grant", ras_falls, f0);
    while (req && g < 10) begin
      gnt = 1'b1;
      step(1);
      gnt = 1'b0;
      g++;
      step(12);
    end
    chk(g == 3, "R8 grants to drain three obligations", g, 3);
    chk(ras_falls == f0 + 3, "R8 one cycle per grant", ras_falls, f0 + 3);
  endtask

  task automatic t_stray_grant();
    int f0 = ras_falls;
    gnt = 1'b1;
    step(5);
    gnt = 1'b0;
    step(2);
    chk(ras_falls == f0, "R12 stray grant ignored", ras_falls, f0);
    chk(req == 1'b0, "R12 no request after stray grant", req, 0);
  endtask

  task automatic t_overflow();
    int n = 0;
    int f0;
    while (!err && n < 8 * INTERVAL) begin step(1); n++; end
    chk(err == 1'b1, "R10 error raised", err, 1);
    chk(ready == 1'b0, "R10 ready withdrawn", ready, 0);
    f0 = ras_falls;
    n = 0;
    while (!ready && n < 2000) begin step(1); n++; end
    chk(ras_falls - f0 == WAKE, "R10 wake rerun count", ras_falls - f0, WAKE);
    chk(err == 1'b1, "R10 error sticky", err, 1);
    chk(req == 1'b0, "R10 backlog cleared", req, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    step(3);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_power_up();
    t_first_req();
    t_backlog_grants();
    t_stray_grant();
    t_overflow();
    step(5);
    summary();
  end
endmodule